// File: doc/BRIEF.md
# 3x3 Image Convolution Datapath

This block filters a raster image with a 3x3 kernel, one pixel per clock. Pixels of the current row enter directly. Two programmable row delay lines hold the previous two rows, so that three vertically adjacent pixels reach the tap window together. A window of nine tap registers feeds nine multipliers. The products are summed with a shifted 16-bit cascade input, and the result is cut to 20 bits and optionally rounded. A valid flag marks the first output whose window holds only real pixels.

The delay-line length is the image row length. When it is set to 3, the three rows chain into a single nine-tap line, and the block works as a 1x9 FIR filter. For cascading, the two older rows can be taken from external ports instead of the internal delay lines. Up to three extra register stages can be placed in the incoming pixel path to line the block up with neighbouring devices.

Top module: `img_conv3x3`

## Requirements
- R1: While `rst` is high, `vld_o` is 0 and `res_o` is 0.
- R2: With row length L, tap t(k,j) after clock edge n holds the pixel taken k rows and j columns earlier: `pix_i` sampled at edge n-k*L-j. Coefficient i = 3k+j sits in `coef_i[8i+7:8i]`. The output after edge m is the low 20 bits of the sum over i of coef(i)*t(k,j) taken at edge m-3, plus the shifted cascade term sampled at edge m-2.
- R3: `row_len_i` gives the row length directly for values from 1 to MAX_ROW-1. The value 0 means MAX_ROW.
- R4: With row length 3, the output is sum over i of coef(i)*x[n-i], which is a 1x9 FIR over the pixel stream.
- R5: `pix_signed_i`=1 reads pixels as two's complement, and 0 reads them as unsigned. `coef_signed_i` does the same for the coefficients.
- R6: `in_dly_i` (0..3) inserts that many register stages before the taps. Every pixel reference in R2 moves D edges earlier.
- R7: With `src_ext_i`=1, rows k=1 and k=2 of the window are fed from `ext_row1_i` and `ext_row2_i`, sampled one edge per column, instead of from the delay lines.
- R8: `casc_sh_i` codes 00/01/10/11 shift `casc_i`, read as two's complement, left by 0/2/4/8 bits before it is added.
- R9: `rnd_mode_i`=01 adds 8 to the 20-bit result and clears bits 3:0.
- R10: `rnd_mode_i`=10 adds 0x800 to the 20-bit result and clears bits 11:0.
- R11: `rnd_mode_i` values 00 and 11 pass the 20-bit result unrounded.
- R12: After reset, `vld_o` rises after edge 2L+D+5 (edge 0 is the first edge with reset low) and then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_i | input | 8 | Incoming pixel, one per clock |
| coef_i | input | 72 | Nine kernel coefficients, index i at bits 8i+7:8i |
| casc_i | input | 16 | Cascade value added to the sum |
| ext_row1_i | input | 8 | External pixel for the middle row |
| ext_row2_i | input | 8 | External pixel for the oldest row |
| row_len_i | input | log2(MAX_ROW) | Row length, 0 means MAX_ROW |
| src_ext_i | input | 1 | 1: older rows come from the external ports |
| in_dly_i | input | 2 | Extra input register stages |
| pix_signed_i | input | 1 | Pixel format, 1 = two's complement |
| coef_signed_i | input | 1 | Coefficient format, 1 = two's complement |
| rnd_mode_i | input | 2 | Output rounding select |
| casc_sh_i | input | 2 | Cascade shift select |
| res_o | output | 20 | Filtered result |
| vld_o | output | 1 | Result is from a fully filled window |

## Verification
Random pixel streams are first run with a short row length. A wrong row-line length or a swapped tap order changes the sum, which a uniform image would hide. Row length 3 then checks the chained 1x9 ordering, and encoding 0 checks the full-length line. Signed runs produce negative products and sums, so a sign error in the extension or the rounding carry becomes visible. Runs with extra input delay, with each cascade shift and with external rows separate latency errors from datapath errors. Each run compares the cycle where valid rises against the formula.

// File: rtl/conv_pkg.sv
package conv_pkg;
    localparam int PIX_W   = 8;
    localparam int COEF_W  = 8;
    localparam int KDIM    = 3;
    localparam int TAPS    = KDIM * KDIM;
    localparam int CASC_W  = 16;
    localparam int RES_W   = 20;
    localparam int PROD_W  = PIX_W + COEF_W + 2;
    localparam int ACC_W   = 26;
    localparam int DROP16  = RES_W - 16;
    localparam int DROP8   = RES_W - 8;
    localparam int MAX_DLY = 3;

    typedef enum logic [1:0] {RND_NONE = 2'b00, RND_16 = 2'b01, RND_8 = 2'b10, RND_BAD = 2'b11} rnd_e;
    typedef enum logic [1:0] {CSH_0 = 2'b00, CSH_2 = 2'b01, CSH_4 = 2'b10, CSH_8 = 2'b11} csh_e;

    typedef struct packed {
        logic src_ext;
        logic pix_signed;
        logic coef_signed;
        rnd_e rnd;
        csh_e csh;
    } cfg_t;

    function automatic logic signed [PIX_W:0] widen(logic [PIX_W-1:0] v, logic sgn);
        return sgn ? {v[PIX_W-1], v} : {1'b0, v};
    endfunction

    function automatic logic signed [ACC_W-1:0] casc_shift(logic [CASC_W-1:0] c, csh_e s);
        logic signed [ACC_W-1:0] e;
        e = {{(ACC_W-CASC_W){c[CASC_W-1]}}, c};
        case (s)
            CSH_2:   return e <<< 2;
            CSH_4:   return e <<< 4;
            CSH_8:   return e <<< 8;
            default: return e;
        endcase
    endfunction

    function automatic logic [RES_W-1:0] round_res(logic [RES_W-1:0] v, rnd_e m);
        logic [RES_W-1:0] t;
        case (m)
            RND_16: begin
                t = v + (RES_W'(1) << (DROP16 - 1));
                t = t & ~((RES_W'(1) << DROP16) - RES_W'(1));
            end
            RND_8: begin
                t = v + (RES_W'(1) << (DROP8 - 1));
                t = t & ~((RES_W'(1) << DROP8) - RES_W'(1));
            end
            default: t = v;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/conv_in_delay.sv
module conv_in_delay #(
    parameter int W    = 8,
    parameter int MAXD = 3,
    localparam int SW  = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  d_i,
    input  logic [SW-1:0] sel_i,
    output logic [W-1:0]  d_o
);
    logic [MAXD-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < MAXD; i++) stg[i] <= stg[i-1];
        end
    end

    always_comb begin
        if (sel_i == '0) d_o = d_i;
        else             d_o = stg[sel_i - SW'(1)];
    end
endmodule

// File: rtl/conv_row_line.sv
module conv_row_line #(
    parameter int W    = 8,
    parameter int MAXL = 1024,
    localparam int AW  = $clog2(MAXL),
    localparam int LW  = $clog2(MAXL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] len_i,
    input  logic [W-1:0]  d_i,
    output logic [W-1:0]  d_o
);
    logic [W-1:0]  mem [MAXL];
    logic [AW-1:0] wp;

    // read-before-write at the same slot gives a delay of exactly len_i samples
    assign d_o = mem[wp];

    always_ff @(posedge clk) begin
        mem[wp] <= d_i;
    end

    always_ff @(posedge clk) begin
        if (rst)                            wp <= '0;
        else if (LW'(wp) >= len_i - LW'(1)) wp <= '0;
        else                                wp <= wp + AW'(1);
    end

    p_ptr_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        LW'(wp) < len_i);
endmodule

// File: rtl/conv_window.sv
module conv_window
    import conv_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [KDIM-1:0][PIX_W-1:0]  row_i,
    output logic [TAPS-1:0][PIX_W-1:0]  tap_o
);
    for (genvar k = 0; k < KDIM; k++) begin : g_row
        logic [KDIM-1:0][PIX_W-1:0] sr;
        always_ff @(posedge clk) begin
            if (rst) begin
                sr <= '0;
            end else begin
                sr[0] <= row_i[k];
                for (int j = 1; j < KDIM; j++) sr[j] <= sr[j-1];
            end
        end
        for (genvar j = 0; j < KDIM; j++) begin : g_col
            assign tap_o[KDIM*k + j] = sr[j];
        end
    end
endmodule

// File: rtl/conv_mac.sv
module conv_mac
    import conv_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  cfg_t                         cfg_i,
    input  logic [TAPS-1:0][PIX_W-1:0]   tap_i,
    input  logic [TAPS-1:0][COEF_W-1:0]  coef_i,
    input  logic [CASC_W-1:0]            casc_i,
    output logic [RES_W-1:0]             res_o
);
    logic signed [PROD_W-1:0] prod [TAPS];
    logic signed [ACC_W-1:0]  cas_r;
    logic signed [ACC_W-1:0]  sum_r;
    logic signed [ACC_W-1:0]  sum_c;

    // stage 1: multipliers and cascade alignment
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) prod[i] <= '0;
            cas_r <= '0;
        end else begin
            for (int i = 0; i < TAPS; i++)
                prod[i] <= PROD_W'(widen(tap_i[i], cfg_i.pix_signed) *
                                   widen(coef_i[i], cfg_i.coef_signed));
            cas_r <= casc_shift(casc_i, cfg_i.csh);
        end
    end

    // stage 2: adder tree
    always_comb begin
        sum_c = cas_r;
        for (int i = 0; i < TAPS; i++) sum_c = sum_c + ACC_W'(prod[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) sum_r <= '0;
        else     sum_r <= sum_c;
    end

    // stage 3: truncation and rounding
    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= round_res(sum_r[RES_W-1:0], cfg_i.rnd);
    end

    p_round16_lsbs_r9: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_i.rnd) == RND_16 |-> res_o[DROP16-1:0] == '0);
    p_round8_lsbs_r10: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_i.rnd) == RND_8 |-> res_o[DROP8-1:0] == '0);
    p_casc_shift8_r8: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_i.csh) == CSH_8 |-> cas_r[7:0] == '0);
endmodule

// File: rtl/img_conv3x3.sv
module img_conv3x3
    import conv_pkg::*;
#(
    parameter int  MAX_ROW = 1024,
    localparam int RLW     = $clog2(MAX_ROW)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PIX_W-1:0]         pix_i,
    input  logic [TAPS*COEF_W-1:0]   coef_i,
    input  logic [CASC_W-1:0]        casc_i,
    input  logic [PIX_W-1:0]         ext_row1_i,
    input  logic [PIX_W-1:0]         ext_row2_i,
    input  logic [RLW-1:0]           row_len_i,
    input  logic                     src_ext_i,
    input  logic [1:0]               in_dly_i,
    input  logic                     pix_signed_i,
    input  logic                     coef_signed_i,
    input  logic [1:0]               rnd_mode_i,
    input  logic [1:0]               casc_sh_i,
    output logic [RES_W-1:0]         res_o,
    output logic                     vld_o
);
    localparam int LW = $clog2(MAX_ROW + 1);
    localparam int CW = $clog2(2 * MAX_ROW + 16);

    cfg_t                        cfg;
    logic [LW-1:0]               len_eff;
    logic [PIX_W-1:0]            pix_d, line1, line2;
    logic [KDIM-1:0][PIX_W-1:0]  rows;
    logic [TAPS-1:0][PIX_W-1:0]  taps;
    logic [TAPS-1:0][COEF_W-1:0] coefs;
    logic [CW-1:0]               cnt, thr;

    assign cfg.src_ext     = src_ext_i;
    assign cfg.pix_signed  = pix_signed_i;
    assign cfg.coef_signed = coef_signed_i;
    assign cfg.rnd         = rnd_e'(rnd_mode_i);
    assign cfg.csh         = csh_e'(casc_sh_i);
    assign coefs           = coef_i;
    assign len_eff = (row_len_i == '0) ? LW'(MAX_ROW) : LW'(row_len_i);

    conv_in_delay #(.W(PIX_W), .MAXD(MAX_DLY)) u_dly (
        .clk(clk), .rst(rst), .d_i(pix_i), .sel_i(in_dly_i), .d_o(pix_d));

    conv_row_line #(.W(PIX_W), .MAXL(MAX_ROW)) u_line1 (
        .clk(clk), .rst(rst), .len_i(len_eff), .d_i(pix_d), .d_o(line1));

    conv_row_line #(.W(PIX_W), .MAXL(MAX_ROW)) u_line2 (
        .clk(clk), .rst(rst), .len_i(len_eff), .d_i(line1), .d_o(line2));

    assign rows[0] = pix_d;
    assign rows[1] = cfg.src_ext ? ext_row1_i : line1;
    assign rows[2] = cfg.src_ext ? ext_row2_i : line2;

    conv_window u_win (.clk(clk), .rst(rst), .row_i(rows), .tap_o(taps));

    conv_mac u_mac (
        .clk(clk), .rst(rst), .cfg_i(cfg), .tap_i(taps), .coef_i(coefs),
        .casc_i(casc_i), .res_o(res_o));

    // fill tracking: two rows, three columns, extra input stages, three pipe stages
    assign thr = (CW'(len_eff) << 1) + CW'(in_dly_i) + CW'(5);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (cnt <= thr) cnt <= cnt + CW'(1);
    end

    assign vld_o = (cnt > thr);

    p_valid_holds_r12: assert property (@(posedge clk) disable iff (rst)
        vld_o |=> vld_o);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (res_o == '0));
endmodule

// File: tb/sim_img_conv3x3.sv
module sim_img_conv3x3;
    localparam int MR  = 16;
    localparam int RLW = $clog2(MR);

    typedef struct {
        int m;
        bit v;
        int val;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      pix = '0, e1 = '0, e2 = '0;
    logic [71:0]     coef = '0;
    logic [15:0]     casc = '0;
    logic [RLW-1:0]  rl = RLW'(5);
    logic            src_ext = 1'b0, psg = 1'b0, csg = 1'b0;
    logic [1:0]      dly = '0, rnd = '0, sh = '0;
    logic [19:0]     res;
    logic            vld;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R2";
    exp_t  q[$];
    int    px[0:255], h1[0:255], h2[0:255], hc[0:255];
    int    cf[9];
    int    cL, cD, cext, cps, ccs, crnd, csh;

    img_conv3x3 #(.MAX_ROW(MR)) u0 (
        .clk(clk), .rst(rst), .pix_i(pix), .coef_i(coef), .casc_i(casc),
        .ext_row1_i(e1), .ext_row2_i(e2), .row_len_i(rl), .src_ext_i(src_ext),
        .in_dly_i(dly), .pix_signed_i(psg), .coef_signed_i(csg),
        .rnd_mode_i(rnd), .casc_sh_i(sh), .res_o(res), .vld_o(vld));

    always #2.5ns clk = ~clk;

    function automatic int sx8(int v, int s);
        return (s != 0 && v > 127) ? v - 256 : v;
    endfunction

    // expected result after edge m, straight from R2..R11
    function automatic int model(int m);
        int n, dn, acc, x, c, r, sa;
        n = m - 3;
        dn = n - cD;
        acc = 0;
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 3; j++) begin
                if (k == 0)       x = px[dn - j];
                else if (cext != 0) x = (k == 1) ? h1[n - j] : h2[n - j];
                else              x = px[dn - k * cL - j];
                acc += sx8(x, cps) * sx8(cf[3 * k + j], ccs);
            end
        end
        c = hc[m - 2];
        if (c > 32767) c -= 65536;
        sa = (csh == 0) ? 0 : (csh == 1) ? 2 : (csh == 2) ? 4 : 8;
        acc += c * (1 << sa);
        r = acc & 'hFFFFF;
        if (crnd == 1) r = (r + 'h8) & 'hFFFF0;
        if (crnd == 2) r = (r + 'h800) & 'hFF000;
        return r & 'hFFFFF;
    endfunction

    // monitor: pops one expected item per edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #1ns;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (vld !== e.v) begin
                    errors++;
                    $display("FAIL %s/R12 m=%0d vld actual=%0b expected=%0b", cur_req, e.m, vld, e.v);
                end
                if (e.v) begin
                    checks++;
                    if (res !== e.val[19:0]) begin
                        errors++;
                        $display("FAIL %s m=%0d res actual=%05h expected=%05h", cur_req, e.m, res, e.val[19:0]);
                    end
                end
            end
        end
    end

    task automatic run_case(int enc, int ext, int d, int ps, int cs, int rm, int s, string req);
        int thr, ns;
        exp_t it;
        rst = 1'b1;
        rl = RLW'(enc);
        src_ext = ext[0];
        dly = d[1:0];
        psg = ps[0];
        csg = cs[0];
        rnd = rm[1:0];
        sh = s[1:0];
        cL = (enc == 0) ? MR : enc;
        cD = d; cext = ext; cps = ps; ccs = cs; crnd = rm; csh = s;
        for (int i = 0; i < 9; i++) begin
            cf[i] = int'($urandom & 255);
            coef[8*i +: 8] = cf[i][7:0];
        end
        repeat (2) @(posedge clk);
        #1ns;
        checks++;
        if (vld !== 1'b0 || res !== 20'h0) begin
            errors++;
            $display("FAIL R1 reset vld=%0b res=%05h expected vld=0 res=00000", vld, res);
        end
        @(negedge clk);
        cur_req = req;
        thr = 2 * cL + cD + 5;
        ns = thr + 30;
        rst = 1'b0;
        for (int m = 0; m < ns; m++) begin
            px[m] = int'($urandom & 255);
            h1[m] = int'($urandom & 255);
            h2[m] = int'($urandom & 255);
            hc[m] = int'($urandom & 16'hFFFF);
            pix  = px[m][7:0];
            e1   = h1[m][7:0];
            e2   = h2[m][7:0];
            casc = hc[m][15:0];
            it.m = m;
            it.v = (m >= thr);
            it.val = (m >= thr) ? model(m) : 0;
            q.push_back(it);
            @(negedge clk);
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    initial begin
        run_case(5, 0, 0, 0, 0, 0, 0, "R2");
        run_case(3, 0, 0, 0, 0, 0, 0, "R4");
        run_case(0, 0, 0, 0, 0, 0, 1, "R3");
        run_case(4, 0, 0, 1, 1, 0, 2, "R5");
        run_case(4, 0, 3, 0, 0, 0, 0, "R6");
        run_case(6, 0, 1, 1, 0, 0, 3, "R8");
        run_case(4, 0, 2, 1, 1, 1, 1, "R9");
        run_case(5, 0, 0, 1, 1, 2, 3, "R10");
        run_case(4, 0, 1, 0, 1, 3, 2, "R11");
        run_case(6, 1, 0, 0, 0, 0, 0, "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule